// File: doc/BRIEF.md
# SPI Slave Serial Front End with Hold

This block is the pin-facing half of a serial memory slave. It watches chip select, serial clock, serial data in and a hold line, all oversampled by a fast system clock. It turns the serial stream into whole bytes. Each byte goes to the command layer behind it with a one-cycle valid strobe and the byte's position within the current command. In the other direction it takes the byte the command layer supplies and shifts it out one bit per falling serial clock edge. The output enable tells the pad when to drive and when to float.

The front end accepts both idle clock levels: low (mode 0) and high (mode 3). Input is sampled on rising edges and output moves after falling edges. A hold input pauses a transfer without deselecting. Hold takes effect and releases only while the serial clock is low. Deselecting mid-byte, or while paused, throws the command away and signals the abort to the command layer. Opcode decoding and storage belong to the command layer.

Top module: `spi_hold_frontend`

## Requirements
- R1: Each eighth accepted rising serial clock edge of a selected transfer produces exactly one system-clock pulse on rx_valid_o. On that pulse, rx_byte_o holds the eight sampled bits, with the first sampled bit in bit 7.
- R2: Transfers are accepted with the serial clock idling low (mode 0) or idling high (mode 3) at the chip-select falling edge, with identical received data.
- R3: rx_index_o is 0 for the first byte after a chip-select falling edge and rises by 1 per byte. It saturates at 2^IDX_W-1 (15 by default).
- R4: Deselecting after 1 to 7 bits of a byte gives one cmd_abort_o pulse and no rx_valid_o. The next selection starts a fresh byte at index 0.
- R5: Deselecting on a byte boundary while not paused gives no cmd_abort_o pulse.
- R6: Hold starts at the first moment the hold input is low while the serial clock is low, whether hold fell during a low or a high clock phase. While paused, serial clock edges neither sample data nor shift output.
- R7: Hold ends only when the hold input is high while the serial clock is low. Reception then continues from the bit where it stopped.
- R8: miso_oe_o is low whenever chip select is high, while paused, and while tx_en_i is low.
- R9: At the first falling serial clock edge after a byte boundary, tx_byte_i is loaded, with a one-cycle tx_load_o pulse. Its bit 7 appears on miso_o, and each later falling edge presents the next lower bit.
- R10: Deselecting while paused clears the pause and gives a cmd_abort_o pulse. If hold is still low at the next selection, the block pauses again at once and receives nothing until hold rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Hold, active low |
| tx_en_i | input | 1 | Command layer is in an output phase |
| tx_byte_i | input | BYTE_W | Next byte to shift out |
| rx_byte_o | output | BYTE_W | Last assembled byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_byte_o |
| rx_index_o | output | IDX_W | Byte position within the command |
| tx_load_o | output | 1 | One-cycle strobe when tx_byte_i is taken |
| cmd_abort_o | output | 1 | One-cycle strobe: command abandoned |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Serial data out drive enable |

## Verification
Multi-byte commands are sent in mode 0 and in mode 3 with varied bit patterns. This separates an MSB/LSB ordering error, an off-by-one bit count and an idle-level dependence. Hold is applied in two ways: once dropped during a low clock phase, and once dropped and released during a high clock phase. Junk clocks are sent while paused, so a front end that gates edges at the wrong moment corrupts the byte. Deselection is tried mid-byte, on a boundary and while paused, with hold both released and still low at reselection. This exposes abort and reset errors. Output bytes are checked from captured data-out bits in both modes, together with the load strobe count and a long command that drives the index to saturation.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic hold_n;
  } spi_pins_t;

  localparam int PIN_CNT = $bits(spi_pins_t);
  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int            WIDTH   = 4,
  parameter int            STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic sck_s_i,
  input  logic hold_n_s_i,
  output logic held_o
);
  logic held_q;

  // state changes only at a low clock level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   held_q <= 1'b0;
    else if (cs_n_s_i)                             held_q <= 1'b0;
    else if (!held_q && !hold_n_s_i && !sck_s_i)   held_q <= 1'b1;
    else if (held_q && hold_n_s_i && !sck_s_i)     held_q <= 1'b0;
  end

  assign held_o = held_q;

  AST_HOLD_ENTRY_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(!sck_s_i && !hold_n_s_i));                   // R6
  AST_HOLD_EXIT_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(held_q) |-> $past(cs_n_s_i || (!sck_s_i && hold_n_s_i)));       // R7
  AST_HOLD_CLEARED_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !held_q);                                               // R10
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              cs_rise_i,
  input  logic              held_i,
  input  logic              rise_ok_i,
  input  logic              fall_ok_i,
  input  logic              mosi_s_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic [IDX_W-1:0]  rx_index_o,
  output logic              tx_load_o,
  output logic              abort_o,
  output logic              miso_bit_o
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  byte_idx_q;
  logic [BYTE_W-1:0] rx_sh_q, tx_sh_q;
  logic [BYTE_W-1:0] rx_next;
  logic              byte_done;

  assign rx_next   = {rx_sh_q[BYTE_W-2:0], mosi_s_i};
  assign byte_done = rise_ok_i && (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      rx_sh_q    <= '0;
    end else if (cs_n_s_i) begin
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
    end else if (rise_ok_i) begin
      rx_sh_q   <= rx_next;
      bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
      if (byte_done && byte_idx_q != IDX_MAX) byte_idx_q <= byte_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      rx_index_o <= '0;
      abort_o    <= 1'b0;
    end else begin
      rx_valid_o <= byte_done && !cs_n_s_i;
      abort_o    <= cs_rise_i && (bit_cnt_q != '0 || held_i);
      if (byte_done && !cs_n_s_i) begin
        rx_byte_o  <= rx_next;
        rx_index_o <= byte_idx_q;
      end
    end
  end

  // output side: reload on the first falling edge of each byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q    <= '0;
      miso_bit_o <= 1'b0;
      tx_load_o  <= 1'b0;
    end else begin
      tx_load_o <= 1'b0;
      if (cs_n_s_i) begin
        tx_sh_q    <= '0;
        miso_bit_o <= 1'b0;
      end else if (fall_ok_i) begin
        if (bit_cnt_q == '0) begin
          miso_bit_o <= tx_byte_i[BYTE_W-1];
          tx_sh_q    <= {tx_byte_i[BYTE_W-2:0], 1'b0};
          tx_load_o  <= 1'b1;
        end else begin
          miso_bit_o <= tx_sh_q[BYTE_W-1];
          tx_sh_q    <= {tx_sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);                                         // R1
  AST_INDEX_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_s_i && $past(!cs_n_s_i)) |-> byte_idx_q >= $past(byte_idx_q)); // R3
  AST_ABORT_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> cs_n_s_i);                                               // R4
  AST_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);                                           // R9
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
  import spi_fe_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int IDX_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  input  logic              tx_en_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic [IDX_W-1:0]  rx_index_o,
  output logic              tx_load_o,
  output logic              cmd_abort_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  spi_pins_t pins_raw, pins_s;
  logic      cs_d_q, sck_d_q;
  logic      cs_rise, sck_rise, sck_fall;
  logic      held, rise_ok, fall_ok;
  logic      oe_q;

  assign pins_raw = '{cs_n: cs_n_i, sck: sck_i, mosi: mosi_i, hold_n: hold_n_i};

  spi_fe_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      cs_d_q  <= pins_s.cs_n;
      sck_d_q <= pins_s.sck;
    end
  end

  assign cs_rise  = !cs_d_q && pins_s.cs_n;
  assign sck_rise = !sck_d_q && pins_s.sck;
  assign sck_fall = sck_d_q && !pins_s.sck;
  assign rise_ok  = sck_rise && !pins_s.cs_n && !held;
  assign fall_ok  = sck_fall && !pins_s.cs_n && !held;

  spi_fe_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (pins_s.cs_n),
    .sck_s_i   (pins_s.sck),
    .hold_n_s_i(pins_s.hold_n),
    .held_o    (held)
  );

  spi_fe_shift #(
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_s_i  (pins_s.cs_n),
    .cs_rise_i (cs_rise),
    .held_i    (held),
    .rise_ok_i (rise_ok),
    .fall_ok_i (fall_ok),
    .mosi_s_i  (pins_s.mosi),
    .tx_byte_i (tx_byte_i),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .rx_index_o(rx_index_o),
    .tx_load_o (tx_load_o),
    .abort_o   (cmd_abort_o),
    .miso_bit_o(miso_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= !pins_s.cs_n && !held && tx_en_i;

  assign miso_oe_o = oe_q;

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.cs_n |=> !miso_oe_o);                                         // R8
  AST_OE_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |=> !miso_oe_o);                                                // R8
  AST_NO_SAMPLE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s.cs_n |=> !rx_valid_o);                                        // R1
endmodule

// File: tb/tb_spi_hold_frontend.sv
module tb_spi_hold_frontend;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;
  localparam int HALF   = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0, hold_n_i = 1'b1, tx_en_i = 1'b0;
  logic [BYTE_W-1:0] tx_byte_i = '0;
  logic [BYTE_W-1:0] rx_byte_o;
  logic              rx_valid_o, tx_load_o, cmd_abort_o, miso_o, miso_oe_o;
  logic [IDX_W-1:0]  rx_index_o;

  int checks = 0, fails = 0, aborts = 0, loads = 0, idx = 0;
  bit done = 0;
  logic [IDX_W+BYTE_W-1:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  spi_hold_frontend #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each strobe
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (cmd_abort_o) aborts++;
      if (tx_load_o) loads++;
      if (rx_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected byte", int'(rx_byte_o), -1);
        else begin
          logic [IDX_W+BYTE_W-1:0] e;
          e = exp_q.pop_front();
          check({rx_index_o, rx_byte_o} == e, "R1/R3 byte,index", int'({rx_index_o, rx_byte_o}), int'(e));
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic spi_bit(input logic b, output logic so);
    sck_i = 1'b0; mosi_i = b; wait_n(HALF);
    so = miso_o;
    sck_i = 1'b1; wait_n(HALF);
  endtask

  task automatic begin_cmd(input bit mode3);
    sck_i = mode3; wait_n(HALF);
    cs_n_i = 1'b0; wait_n(HALF);
    idx = 0;
  endtask

  task automatic end_cmd(input bit mode3);
    if (!mode3) begin sck_i = 1'b0; wait_n(HALF); end
    cs_n_i = 1'b1; wait_n(3 * HALF);
  endtask

  task automatic push_exp(input logic [BYTE_W-1:0] b);
    exp_q.push_back({IDX_W'(idx > 15 ? 15 : idx), b});
    idx++;
  endtask

  task automatic send_byte(input logic [BYTE_W-1:0] b, input bit expect_rx, output logic [BYTE_W-1:0] so_b);
    if (expect_rx) push_exp(b);
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      logic s;
      spi_bit(b[i], s);
      so_b[i] = s;
    end
  endtask

  task automatic queue_drained(input string req);
    wait_n(4);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [BYTE_W-1:0] so;
    logic s;
    int a0, l0;
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(5);
    check(!rx_valid_o && !miso_oe_o && !cmd_abort_o, "R8 reset outputs", {rx_valid_o, miso_oe_o, cmd_abort_o}, 0);

    // mode 0, three bytes
    a0 = aborts;
    begin_cmd(1'b0);
    send_byte(8'h03, 1, so); send_byte(8'h12, 1, so); send_byte(8'hC4, 1, so);
    end_cmd(1'b0);
    queue_drained("R1 mode0 bytes received");
    check(aborts == a0, "R5 boundary deselect no abort", aborts - a0, 0);

    // mode 3 receive plus transmit (R2, R9)
    l0 = loads;
    begin_cmd(1'b1);
    send_byte(8'h9A, 1, so);
    tx_en_i = 1'b1; tx_byte_i = 8'hB6;
    send_byte(8'h5F, 1, so);
    check(so == 8'hB6, "R9 mode3 tx byte1", so, 8'hB6);
    tx_byte_i = 8'h4D;
    send_byte(8'h81, 1, so);
    check(so == 8'h4D, "R9 mode3 tx byte2", so, 8'h4D);
    end_cmd(1'b1);
    tx_en_i = 1'b0;
    queue_drained("R2 mode3 bytes received");
    check(loads - l0 == 3, "R9 load strobes mode3", loads - l0, 3);

    // hold while clock low, mode 0, with output (R6 R7 R8 R9)
    begin_cmd(1'b0);
    check(!miso_oe_o, "R8 oe off with tx_en low", miso_oe_o, 0);
    send_byte(8'hA1, 1, so);
    tx_en_i = 1'b1; tx_byte_i = 8'h3C;
    push_exp(8'h6B);
    for (int i = 7; i >= 5; i--) begin spi_bit(8'h6B >> i, s); so[i] = s; end
    sck_i = 1'b0; wait_n(HALF);
    hold_n_i = 1'b0; wait_n(HALF);
    check(!miso_oe_o, "R8 oe off in hold", miso_oe_o, 0);
    for (int j = 0; j < 3; j++) begin
      mosi_i = j[0]; sck_i = 1'b1; wait_n(HALF);
      sck_i = 1'b0; wait_n(HALF);
    end
    hold_n_i = 1'b1; wait_n(HALF);
    check(miso_oe_o, "R7 oe back after hold", miso_oe_o, 1);
    for (int i = 4; i >= 0; i--) begin spi_bit(8'h6B >> i, s); so[i] = s; end
    check(so == 8'h3C, "R6 tx intact across hold", so, 8'h3C);
    end_cmd(1'b0);
    tx_en_i = 1'b0;
    queue_drained("R6 rx intact across hold");

    // hold dropped and released with clock high, mode 3 (R6 R7)
    begin_cmd(1'b1);
    push_exp(8'hD2);
    for (int i = 7; i >= 4; i--) spi_bit(8'hD2 >> i, s);
    hold_n_i = 1'b0; wait_n(HALF);
    for (int j = 0; j < 2; j++) begin
      mosi_i = ~mosi_i; sck_i = 1'b0; wait_n(HALF);
      sck_i = 1'b1; wait_n(HALF);
    end
    hold_n_i = 1'b1; wait_n(HALF);
    for (int i = 3; i >= 0; i--) spi_bit(8'hD2 >> i, s);
    send_byte(8'h2E, 1, so);
    end_cmd(1'b1);
    queue_drained("R7 late hold release keeps bits");

    // mid-byte deselect (R4)
    a0 = aborts;
    begin_cmd(1'b0);
    for (int i = 0; i < 3; i++) spi_bit(1'b1, s);
    end_cmd(1'b0);
    check(aborts - a0 == 1, "R4 abort on partial byte", aborts - a0, 1);
    begin_cmd(1'b0);
    send_byte(8'h7E, 1, so);
    end_cmd(1'b0);
    queue_drained("R4 restart at index 0");

    // deselect while paused, reselect with hold still low (R10)
    a0 = aborts;
    begin_cmd(1'b0);
    for (int i = 0; i < 2; i++) spi_bit(1'b0, s);
    sck_i = 1'b0; wait_n(HALF);
    hold_n_i = 1'b0; wait_n(HALF);
    cs_n_i = 1'b1; wait_n(3 * HALF);
    check(aborts - a0 == 1, "R10 abort on deselect in hold", aborts - a0, 1);
    begin_cmd(1'b0);
    send_byte(8'hFF, 0, so);
    end_cmd(1'b0);
    check(aborts - a0 == 2, "R10 reentered hold at reselect", aborts - a0, 2);
    hold_n_i = 1'b1; wait_n(HALF);
    begin_cmd(1'b0);
    send_byte(8'h44, 1, so);
    end_cmd(1'b0);
    queue_drained("R10 resume after hold high");

    // index saturation (R3)
    begin_cmd(1'b0);
    for (int k = 0; k < 18; k++) send_byte(8'(k * 37 + 5), 1, so);
    end_cmd(1'b0);
    queue_drained("R3 index saturates");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule